// File: doc/BRIEF.md
# Wake-on-Ring Resume Request Generator

This block is a control-register slice for a USB device controller. It holds five control bits, which are written and read through a plain single-cycle port. These bits are a debug-mode enable, a clock-source override, a ring polarity select, a wake-on-ring enable and a software resume control. The debug and clock-override bits leave the block as level outputs. The link logic and the clock multiplexer outside the block act on them.

An external ring-indicate line passes through a two-flop synchroniser and is compared with the programmed active level. A wake-on-ring resume request goes to the USB link logic only when several things are true together: the enable bit is set, the synchronised ring line is at its active level, the host has armed remote wakeup, and the device is suspended. The request is a single-cycle pulse. A 0-to-1 transition of the software resume bit also produces a pulse on the same output. The `wake_armed` and `suspended` inputs are assumed to be synchronous to `clk`.

Top module: `wor_ctrl_top`

## Requirements
- R1: After reset every control bit is 0 and `rd_data` reads 0. A write with `wr_en` high updates bits 18, 17, 16, 15 and 14 from `wr_data` at the clock edge, and `rd_data` returns them at the same positions.
- R2: Bits 31..19 and 13..0 of `rd_data` always read 0, whatever value is written.
- R3: `dbg_mode_o` equals register bit 18, and `clk_override_o` equals register bit 15.
- R4: `ring_in` is synchronised by two flops. When a change on `ring_in` makes the gated condition true, `resume_req_o` pulses on the third rising edge after the change.
- R5: Bit 17 selects the ring polarity. With bit 17 = 0 the ring is active when `ring_in` is 0. With bit 17 = 1 it is active when `ring_in` is 1.
- R6: No wake-on-ring pulse occurs unless bit 16 (enable) is 1, `wake_armed` is 1 and `suspended` is 1.
- R7: A wake-on-ring request is exactly one clock wide. It does not repeat while the condition holds, and it fires again only after the condition has dropped and returned.
- R8: A write that takes bit 14 from 0 to 1 produces one `resume_req_o` pulse on the second rising edge after the write edge. Writing 1 when the bit is already 1, or writing 0, produces no pulse.
- R9: If `suspended` or `wake_armed` drops before a ring change has passed the synchroniser, no resume request is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Register write data |
| rd_data | output | 32 | Register read data |
| ring_in | input | 1 | Asynchronous ring-indicate input |
| wake_armed | input | 1 | Host has enabled remote wakeup |
| suspended | input | 1 | Device is in the suspend state |
| dbg_mode_o | output | 1 | Debug-mode enable (bit 18) |
| clk_override_o | output | 1 | Force internal system clock (bit 15) |
| resume_req_o | output | 1 | One-cycle resume request |

## Verification
The bench sweeps all 32 combinations of polarity, enable, wake arming, suspend and ring level. For each one it counts the pulses and the cycle in which they appear. A design with the wrong polarity sense or a missing gate term would pulse in the wrong half of the sweep. A design with an extra or a missing synchroniser stage would pulse in the wrong cycle. Holding the ring active exposes a level-driven output, which would pulse repeatedly. Dropping suspend or arming in the middle of synchronisation exposes a design that latches a pending detection. Repeated writes of the software bit expose a design that pulses on a written 1 rather than on a 0-to-1 transition.

// File: rtl/wor_pkg.sv
// Shared bit positions and the control-bit bundle for the wake-on-ring slice.
package wor_pkg;
    localparam int DATA_W    = 32;
    localparam int DBG_BIT   = 18;
    localparam int LVL_BIT   = 17;
    localparam int EN_BIT    = 16;
    localparam int CLKSEL_BIT = 15;
    localparam int SWRES_BIT = 14;
    localparam int LO_BIT    = SWRES_BIT;
    localparam int HI_BIT    = DBG_BIT;

    typedef struct packed {
        logic dbg;
        logic lvl;
        logic en;
        logic clksel;
        logic swres;
    } ctrl_t;
endpackage

// File: rtl/wor_regs.sv
// Control register: holds the five control bits and returns them on reads.
// Assumes single-cycle writes. All unimplemented bit positions read as zero.
module wor_regs
    import wor_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] rd_data,
    output ctrl_t         ctrl
);
    logic unused_wr_bits;
    assign unused_wr_bits = ^{wr_data[DW-1:HI_BIT+1], wr_data[LO_BIT-1:0]};

    // Capture the implemented bits on a write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= '0;
        end else if (wr_en) begin
            ctrl.dbg    <= wr_data[DBG_BIT];
            ctrl.lvl    <= wr_data[LVL_BIT];
            ctrl.en     <= wr_data[EN_BIT];
            ctrl.clksel <= wr_data[CLKSEL_BIT];
            ctrl.swres  <= wr_data[SWRES_BIT];
        end
    end

    // Assemble the read word, with zeros in the reserved positions.
    always_comb begin
        rd_data             = '0;
        rd_data[DBG_BIT]    = ctrl.dbg;
        rd_data[LVL_BIT]    = ctrl.lvl;
        rd_data[EN_BIT]     = ctrl.en;
        rd_data[CLKSEL_BIT] = ctrl.clksel;
        rd_data[SWRES_BIT]  = ctrl.swres;
    end

    // R1: a write is visible on the read port one edge later
    p_wr_readback_r1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> rd_data[HI_BIT:LO_BIT] == $past(wr_data[HI_BIT:LO_BIT]));
endmodule

// File: rtl/wor_sync.sv
// Multi-flop synchroniser for one asynchronous level input.
// Assumes the input is a slow level, so only metastability needs handling.
module wor_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    // Shift the input through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/wor_resume_gen.sv
// Gates the synchronised ring level and converts it to a resume pulse.
// The condition is edge-detected, so a drop of suspend or arming cancels it.
// Also edge-detects the software resume bit. Output is registered.
// Assumes wake_armed and suspended are synchronous to clk.
module wor_resume_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic ring_s,
    input  logic lvl,
    input  logic en,
    input  logic swres,
    input  logic wake_armed,
    input  logic suspended,
    output logic resume_o
);
    logic match, match_q, sw_q, wor_pulse, sw_pulse;

    // Combined wake-on-ring condition and its rising edges.
    always_comb begin
        match     = en && (ring_s == lvl) && wake_armed && suspended;
        wor_pulse = match && !match_q;
        sw_pulse  = swres && !sw_q;
    end

    // Edge-history flops and the registered resume output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            match_q  <= 1'b0;
            sw_q     <= 1'b0;
            resume_o <= 1'b0;
        end else begin
            match_q  <= match;
            sw_q     <= swres;
            resume_o <= wor_pulse || sw_pulse;
        end
    end

    // R6: a ring pulse only arises with enable, arming and suspend all set
    p_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wor_pulse |-> (en && wake_armed && suspended));
    // R7: the ring pulse never lasts two cycles
    p_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wor_pulse |=> !wor_pulse);
    // R8: the output is traced back to a ring or software edge
    p_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        resume_o |-> ($past(wor_pulse) || $past(sw_pulse)));
    // R9: with suspend low, no resume follows from the ring path
    p_cancel_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!suspended && !sw_pulse) |=> !resume_o);
endmodule

// File: rtl/wor_ctrl_top.sv
// Top of the wake-on-ring control slice: register, synchroniser, pulse generator.
module wor_ctrl_top
    import wor_pkg::*;
#(
    parameter int DW          = DATA_W,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] rd_data,
    input  logic          ring_in,
    input  logic          wake_armed,
    input  logic          suspended,
    output logic          dbg_mode_o,
    output logic          clk_override_o,
    output logic          resume_req_o
);
    ctrl_t ctrl;
    logic  ring_s;

    wor_regs #(.DW(DW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .ctrl(ctrl)
    );

    wor_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(ring_in), .q(ring_s)
    );

    wor_resume_gen u_gen (
        .clk(clk), .rst_n(rst_n), .ring_s(ring_s), .lvl(ctrl.lvl),
        .en(ctrl.en), .swres(ctrl.swres), .wake_armed(wake_armed),
        .suspended(suspended), .resume_o(resume_req_o)
    );

    assign dbg_mode_o     = ctrl.dbg;
    assign clk_override_o = ctrl.clksel;

    // R2: reserved positions never read as one
    p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[DW-1:HI_BIT+1] == '0 && rd_data[LO_BIT-1:0] == '0);
    // R3: the clock override follows the register bit
    p_clksel_r3: assert property (@(posedge clk) disable iff (!rst_n)
        clk_override_o == rd_data[CLKSEL_BIT]);
endmodule

// File: tb/test_wor_ctrl_top.sv
module test_wor_ctrl_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        ring_in = 1'b0;
    logic        wake_armed = 1'b0;
    logic        suspended = 1'b0;
    logic        dbg_mode_o, clk_override_o, resume_req_o;
    int nvec = 0;
    int nerr = 0;

    always #2 clk = ~clk;

    wor_ctrl_top i_wor_ctrl_top (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .ring_in(ring_in), .wake_armed(wake_armed),
        .suspended(suspended), .dbg_mode_o(dbg_mode_o),
        .clk_override_o(clk_override_o), .resume_req_o(resume_req_o)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        nvec++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic logic [31:0] ctl(input bit dbg, lvl, en, cs, sw);
        return (32'(dbg) << 18) | (32'(lvl) << 17) | (32'(en) << 16) |
               (32'(cs) << 15) | (32'(sw) << 14);
    endfunction

    // Count resume pulses over n samples; record the index of the first one.
    task automatic watch(input int n, output int cnt, output int first);
        cnt = 0; first = 0;
        for (int i = 1; i <= n; i++) begin
            @(negedge clk);
            if (resume_req_o) begin
                cnt++;
                if (first == 0) first = i;
            end
        end
    endtask

    initial begin
        #400000;
        nerr++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end

    initial begin
        int cnt, first;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(rd_data == 0, "R1 reset rd_data", rd_data, 0);
        chk(resume_req_o == 0, "R1 reset resume", resume_req_o, 0);
        chk({dbg_mode_o, clk_override_o} == 0, "R3 reset outputs", {dbg_mode_o, clk_override_o}, 0);

        // R1/R2/R3 readback patterns, software bit kept at 0 here
        foreach (wr_data[k]) begin end
        begin
            logic [31:0] pats [4] = '{32'hFFFFBFFF, 32'hA5A5A5A5, 32'h00048000, 32'h00000000};
            for (int p = 0; p < 4; p++) begin
                wr(pats[p]);
                chk(rd_data == (pats[p] & 32'h0007C000), "R1 R2 readback", rd_data, pats[p] & 32'h0007C000);
                chk(dbg_mode_o == pats[p][18], "R3 dbg", dbg_mode_o, pats[p][18]);
                chk(clk_override_o == pats[p][15], "R3 clksel", clk_override_o, pats[p][15]);
            end
        end

        // R4 R5 R6 R7 sweep over polarity, enable, arming, suspend, ring level
        for (int v = 0; v < 32; v++) begin
            bit lvl, en, a, s, r, exp_hit;
            lvl = v[4]; en = v[3]; a = v[2]; s = v[1]; r = v[0];
            exp_hit = en && a && s && (r == lvl);
            suspended = 1'b0; wake_armed = 1'b0; ring_in = ~lvl;
            wr(ctl(0, lvl, en, 0, 0));
            repeat (4) @(negedge clk);
            wake_armed = a; suspended = s;
            repeat (2) @(negedge clk);
            ring_in = r;
            watch(10, cnt, first);
            chk(cnt == int'(exp_hit), "R5 R6 R7 pulse count", cnt, exp_hit);
            if (exp_hit) chk(first == 3, "R4 pulse latency", first, 3);
            if (exp_hit) begin
                // R7 re-fires only after the condition drops and returns
                ring_in = ~lvl;
                watch(5, cnt, first);
                chk(cnt == 0, "R7 no pulse on drop", cnt, 0);
                ring_in = lvl;
                watch(6, cnt, first);
                chk(cnt == 1, "R7 re-fire", cnt, 1);
            end
        end

        // R9 cancellation by suspend or arming dropping mid-synchronisation
        for (int c = 0; c < 2; c++) begin
            suspended = 1'b1; wake_armed = 1'b1; ring_in = 1'b0;
            wr(ctl(0, 1, 1, 0, 0));
            repeat (4) @(negedge clk);
            ring_in = 1'b1;
            @(negedge clk);
            if (c == 0) suspended = 1'b0; else wake_armed = 1'b0;
            watch(8, cnt, first);
            chk(cnt == 0, "R9 cancelled", cnt, 0);
            ring_in = 1'b0; suspended = 1'b0; wake_armed = 1'b0;
        end

        // R8 software resume bit edge
        wr(ctl(0, 0, 0, 0, 0));
        repeat (2) @(negedge clk);
        @(negedge clk); wr_en = 1'b1; wr_data = ctl(0, 0, 0, 0, 1);
        @(negedge clk); wr_en = 1'b0;
        if (resume_req_o) cnt = 1; else cnt = 0;
        chk(cnt == 0, "R8 not yet at first edge", cnt, 0);
        @(negedge clk);
        chk(resume_req_o == 1, "R8 pulse at second edge", resume_req_o, 1);
        watch(5, cnt, first);
        chk(cnt == 0, "R8 single pulse", cnt, 0);
        wr(ctl(0, 0, 0, 0, 1));
        watch(5, cnt, first);
        chk(cnt == 0, "R8 rewrite 1 no pulse", cnt, 0);
        wr(ctl(0, 0, 0, 0, 0));
        watch(5, cnt, first);
        chk(cnt == 0, "R8 write 0 no pulse", cnt, 0);
        wr(ctl(0, 0, 0, 0, 1));
        watch(5, cnt, first);
        chk(cnt == 1, "R8 second rising write", cnt, 1);

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end
endmodule